// File: doc/BRIEF.md
# Boot Image SRAM Preloader

The preloader fills a processor's local SRAM with a boot image before the processor runs. Image data arrives on a valid/ready stream of `BEAT_BYTES`-wide beats. The block packs the beats into 256-bit (32-byte) words and writes each finished word to the next SRAM word address, with at most one write per clock. When the beats are a full 32 bytes wide and arrive back to back, a word is written on every cycle. A freeze output holds the processor stalled from reset until the last word of the image has reached the SRAM.

The image size in bytes comes from a configuration input, which is captured while reset is held. A legal size is non-zero, a multiple of 256, and no larger than the SRAM (2^(ADDR_W+5) bytes). Any other size moves the block into a fault state: the error flag rises, no beat is accepted, and freeze stays high.

The controller has four states. `LD_CHECK` is entered on reset. On the first clock after reset it moves to `LD_LOAD` when the size is legal, or to `LD_FAULT` when it is not. `LD_LOAD` moves to `LD_DONE` on the clock that accepts the beat completing the final word. `LD_DONE` and `LD_FAULT` hold until the next reset.

Top module: `boot_preloader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, freeze is 1, and write enable, address, write data and the error flag are all 0. Ready is 0 during reset.
- R2: A captured size that is zero, not a multiple of 256, or above 2^(ADDR_W+5) bytes sets the error flag from the first cycle after the first clock past reset. From then on, ready stays 0, no write is ever issued, and freeze stays 1.
- R3: For a legal size, ready is 1 from the first cycle after the first clock past reset, and the error flag stays 0.
- R4: Beats fill a word from the least significant end. Byte k of a word (image byte 32·a + k for word a) sits at bits 8k+7:8k, so 32-bit lane i holds image bytes 4i to 4i+3 at bits 32i+31:32i.
- R5: The first write goes to address 0. Each later write goes to the previous address plus one. The number of writes is the image size divided by 32.
- R6: A write is presented in the cycle after the clock that accepts the beat completing a word. With full-width beats offered every cycle, writes come on consecutive cycles, and the first one appears in the second cycle after reset release.
- R7: In a cycle whose preceding clock accepted no word-completing beat, write enable is 0 and the address keeps its last written value.
- R8: Freeze stays 1 throughout loading. It falls in the cycle right after the cycle that presents the final write, and in that cycle write enable is 0.
- R9: After freeze has fallen, ready stays 0, offered beats are ignored, no write occurs, and freeze stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; size is captured while low |
| cfg_img_bytes | input | ADDR_W+6 | Image size in bytes |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted when high with valid |
| s_data | input | BEAT_BYTES*8 | Stream beat, lowest image byte in bits 7:0 |
| sram_addr | output | ADDR_W | SRAM word address |
| sram_we | output | 1 | SRAM write enable |
| sram_wdata | output | 256 | SRAM write data |
| freeze | output | 1 | Processor stall, high until the image is written |
| cfg_err | output | 1 | Illegal image size |

## Verification
A word counter that is off by one shows up at the address of the first write. It also makes freeze fall one word early or late, so the comparison of the final write cycle with the freeze edge catches it within a cycle of the load's end. A packer whose beat index slips corrupts the very first written word, and a state register stuck in the wrong state shows within two cycles of reset as wrong ready, error or freeze values. Each write is compared against the expected address, data and cycle as it happens. The sweep covers full-width beats and narrow beats, three stall patterns, an image that fills the SRAM completely, and every class of illegal size.

// File: rtl/boot_preloader_pkg.sv
package boot_preloader_pkg;
    localparam int WORD_BYTES = 32;
    localparam int WORD_BITS  = WORD_BYTES * 8;
    localparam int ALIGN_BITS = 8;   // image size granule is 256 bytes

    typedef enum logic [1:0] {
        LD_CHECK = 2'd0,
        LD_LOAD  = 2'd1,
        LD_DONE  = 2'd2,
        LD_FAULT = 2'd3
    } ld_state_e;
endpackage

// File: rtl/boot_preloader_sizechk.sv
module boot_preloader_sizechk
    import boot_preloader_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W+5:0] size_bytes,
    output logic              size_bad,
    output logic [ADDR_W:0]   size_words
);
    localparam int SIZE_W = ADDR_W + 6;
    localparam logic [SIZE_W-1:0] MAX_BYTES = SIZE_W'(1) << (ADDR_W + 5);

    always_comb begin
        size_bad = (size_bytes == '0)
                || (size_bytes[ALIGN_BITS-1:0] != '0)
                || (size_bytes > MAX_BYTES);
        size_words = size_bytes[SIZE_W-1:5];
    end
endmodule

// File: rtl/boot_preloader_packer.sv
module boot_preloader_packer
    import boot_preloader_pkg::*;
#(
    parameter int BEAT_BYTES = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept,
    input  logic [BEAT_BYTES*8-1:0]   beat_data,
    output logic                      word_fire,
    output logic [WORD_BITS-1:0]      word_data
);
    localparam int BEAT_W = BEAT_BYTES * 8;
    localparam int BEATS  = WORD_BYTES / BEAT_BYTES;
    localparam int IDX_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [BEATS-1:0][BEAT_W-1:0] acc_q;
    logic [IDX_W-1:0]             idx_q;
    logic                         last_beat;

    assign last_beat = (idx_q == IDX_W'(BEATS - 1));
    assign word_fire = accept && last_beat;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (accept) begin
            acc_q[idx_q] <= beat_data;
            idx_q        <= last_beat ? '0 : idx_q + IDX_W'(1);
        end
    end

    // The closing beat is overlaid straight onto the output word.
    for (genvar l = 0; l < BEATS; l++) begin : g_lane
        assign word_data[l*BEAT_W +: BEAT_W] =
            (idx_q == IDX_W'(l)) ? beat_data : acc_q[l];
    end
endmodule

// File: rtl/boot_preloader.sv
module boot_preloader
    import boot_preloader_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BEAT_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W+5:0]       cfg_img_bytes,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic [BEAT_BYTES*8-1:0] s_data,
    output logic [ADDR_W-1:0]       sram_addr,
    output logic                    sram_we,
    output logic [WORD_BITS-1:0]    sram_wdata,
    output logic                    freeze,
    output logic                    cfg_err
);
    localparam int SIZE_W = ADDR_W + 6;
    localparam int CNT_W  = ADDR_W + 1;

    ld_state_e            state_q, state_nx;
    logic [SIZE_W-1:0]    size_q;
    logic                 size_bad;
    logic [CNT_W-1:0]     total_words;
    logic [CNT_W-1:0]     wr_count_q;
    logic                 accept;
    logic                 word_fire;
    logic [WORD_BITS-1:0] word_data;
    logic                 final_word;

    boot_preloader_sizechk #(.ADDR_W(ADDR_W)) u_size (
        .size_bytes (size_q),
        .size_bad   (size_bad),
        .size_words (total_words)
    );

    boot_preloader_packer #(.BEAT_BYTES(BEAT_BYTES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .beat_data (s_data),
        .word_fire (word_fire),
        .word_data (word_data)
    );

    assign s_ready    = (state_q == LD_LOAD);
    assign accept     = s_valid && s_ready;
    assign final_word = word_fire && (wr_count_q == total_words - CNT_W'(1));

    // size capture while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= cfg_img_bytes;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LD_CHECK: state_nx = size_bad ? LD_FAULT : LD_LOAD;
            LD_LOAD:  if (final_word) state_nx = LD_DONE;
            LD_DONE:  state_nx = LD_DONE;
            LD_FAULT: state_nx = LD_FAULT;
            default:  state_nx = LD_FAULT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LD_CHECK;
            wr_count_q <= '0;
        end else begin
            state_q <= state_nx;
            if (word_fire) begin
                wr_count_q <= wr_count_q + CNT_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_we    <= 1'b0;
            sram_addr  <= '0;
            sram_wdata <= '0;
            freeze     <= 1'b1;
            cfg_err    <= 1'b0;
        end else begin
            sram_we <= word_fire;
            if (word_fire) begin
                sram_addr  <= wr_count_q[ADDR_W-1:0];
                sram_wdata <= word_data;
            end
            freeze  <= (state_q != LD_DONE);
            cfg_err <= (state_nx == LD_FAULT);
        end
    end
endmodule

// File: rtl/boot_preloader_chk.sv
module boot_preloader_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_we,
    input logic              freeze,
    input logic              cfg_err
);
    logic              seen_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (sram_we) begin
            seen_q <= 1'b1;
            last_q <= sram_addr;
        end
    end

    // R6
    we_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> $past(s_valid && s_ready));

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && seen_q) |-> (sram_addr == last_q + ADDR_W'(1)));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr) |-> sram_we);

    // R8
    freeze_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze) |-> (!sram_we && $past(sram_we)));

    // R2
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (freeze && !s_ready && !sram_we));

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |-> (!s_ready && !sram_we));

    // R3
    ready_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (freeze && !cfg_err));
endmodule

bind boot_preloader boot_preloader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .sram_addr (sram_addr),
    .sram_we   (sram_we),
    .freeze    (freeze),
    .cfg_err   (cfg_err)
);

// File: tb/boot_preloader_tb.sv
`timescale 1ns/1ps
module boot_preloader_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [22:0]  w_cfg = '0;
    logic [9:0]   n_cfg = '0;

    logic         w_valid = 1'b0, w_ready, w_we, w_freeze, w_err;
    logic [255:0] w_data = '0, w_wdata;
    logic [16:0]  w_addr;

    logic         n_valid = 1'b0, n_ready, n_we, n_freeze, n_err;
    logic [31:0]  n_data = '0;
    logic [255:0] n_wdata;
    logic [3:0]   n_addr;

    int checks = 0;
    int errors = 0;

    boot_preloader u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_img_bytes(w_cfg),
        .s_valid(w_valid), .s_ready(w_ready), .s_data(w_data),
        .sram_addr(w_addr), .sram_we(w_we), .sram_wdata(w_wdata),
        .freeze(w_freeze), .cfg_err(w_err));

    boot_preloader #(.ADDR_W(4), .BEAT_BYTES(4)) u_dut_narrow (
        .clk(clk), .rst_n(rst_n), .cfg_img_bytes(n_cfg),
        .s_valid(n_valid), .s_ready(n_ready), .s_data(n_data),
        .sram_addr(n_addr), .sram_we(n_we), .sram_wdata(n_wdata),
        .freeze(n_freeze), .cfg_err(n_err));

    task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] img_byte(input int o, input int seed);
        return 8'((o * 13 + seed * 29 + 5) & 255);
    endfunction

    function automatic logic [255:0] exp_word(input int a, input int seed);
        logic [255:0] w;
        for (int k = 0; k < 32; k++) w[8*k +: 8] = img_byte(32 * a + k, seed);
        return w;
    endfunction

    function automatic logic [31:0] exp_beat4(input int j, input int seed);
        logic [31:0] b;
        for (int k = 0; k < 4; k++) b[8*k +: 8] = img_byte(4 * j + k, seed);
        return b;
    endfunction

    function automatic bit pattern(input int mode, input int cyc);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (cyc % 2) == 0;
        return (cyc % 5) < 2;
    endfunction

    task automatic do_reset(input int size);
        rst_n = 1'b0;
        w_valid = 1'b0;
        n_valid = 1'b0;
        w_cfg = 23'(size);
        n_cfg = 10'(size);
        repeat (3) @(negedge clk);
        // R1 reset state, both instances
        chk(w_freeze && !w_we && w_addr == 0 && w_wdata == 0 && !w_err && !w_ready,
            "R1 wide reset outputs", {w_freeze, w_we, w_err, w_ready}, 4'b1000);
        chk(n_freeze && !n_we && n_addr == 0 && n_wdata == 0 && !n_err && !n_ready,
            "R1 narrow reset outputs", {n_freeze, n_we, n_err, n_ready}, 4'b1000);
        rst_n = 1'b1;
    endtask

    task automatic run_load(input bit narrow, input int size, input int mode, input int seed);
        int bb, nbeats, nwords, per_word, beat, wseen, first, last, fall;
        bit exp_we;
        logic rdy, we, frz, err;
        logic [16:0] addr;
        logic [255:0] wd;
        bb = narrow ? 4 : 32;
        nbeats = size / bb;
        nwords = size / 32;
        per_word = 32 / bb;
        beat = 0; wseen = 0; first = -1; last = -1; fall = -1; exp_we = 1'b0;
        do_reset(size);
        for (int cyc = 1; cyc < 3000; cyc++) begin
            @(negedge clk);
            rdy  = narrow ? n_ready : w_ready;
            we   = narrow ? n_we : w_we;
            frz  = narrow ? n_freeze : w_freeze;
            err  = narrow ? n_err : w_err;
            addr = narrow ? 17'(n_addr) : w_addr;
            wd   = narrow ? n_wdata : w_wdata;
            if (cyc == 1) begin
                // R1 first cycle after release still shows reset outputs
                chk(frz && !we && addr == 0 && !err, "R1 first cycle outputs", {frz, we, err}, 3'b100);
                // R3 legal size enters loading
                chk(rdy && !err, "R3 ready after first clock", {rdy, err}, 2'b10);
            end
            // R7 write only after an accepted word-completing beat
            chk(we == exp_we, "R7 write enable timing", we, exp_we);
            if (we) begin
                chk(addr == 17'(wseen), "R5 write address", addr, wseen);
                chk(wd == exp_word(wseen, seed), "R4 packed word", wd, exp_word(wseen, seed));
                if (first < 0) first = cyc;
                last = cyc;
                wseen++;
            end else if (wseen > 0) begin
                // R7 address holds between writes
                chk(addr == 17'(wseen - 1), "R7 address hold", addr, wseen - 1);
            end
            if (fall < 0 && !frz) begin
                fall = cyc;
                // R8 freeze falls only once every word is written
                chk(wseen == nwords && !we, "R8 freeze fall point", wseen, nwords);
            end else if (fall >= 0) begin
                // R9 quiet after completion
                chk(!frz && !rdy && !we, "R9 ignored after done", {frz, rdy, we}, 3'b000);
            end
            if (fall >= 0 && cyc >= fall + 6) break;
            // drive the next beat (also offered after completion, R9)
            if (narrow) begin
                n_valid = (beat < nbeats || fall >= 0) && pattern(mode, cyc);
                n_data = exp_beat4(beat, seed);
            end else begin
                w_valid = (beat < nbeats || fall >= 0) && pattern(mode, cyc);
                w_data = exp_word(beat, seed);
            end
            exp_we = 1'b0;
            if ((narrow ? n_valid : w_valid) && rdy) begin
                exp_we = (beat % per_word) == per_word - 1;
                beat++;
            end
        end
        w_valid = 1'b0;
        n_valid = 1'b0;
        chk(fall >= 0, "R8 freeze released", fall, 1);
        chk(wseen == nwords, "R5 write count", wseen, nwords);
        chk(fall == last + 1, "R8 freeze falls after final write", fall, last + 1);
        if (!narrow && mode == 0) begin
            chk(first == 2, "R6 first write cycle", first, 2);
            chk(last - first == nwords - 1, "R6 back-to-back writes", last - first, nwords - 1);
        end
    endtask

    task automatic run_err(input bit narrow, input int size);
        logic rdy, we, frz, err;
        do_reset(size);
        for (int cyc = 1; cyc <= 12; cyc++) begin
            @(negedge clk);
            rdy = narrow ? n_ready : w_ready;
            we  = narrow ? n_we : w_we;
            frz = narrow ? n_freeze : w_freeze;
            err = narrow ? n_err : w_err;
            // R2 fault state holds everything off
            chk(err && frz && !rdy && !we, "R2 illegal size fault",
                {err, frz, rdy, we}, 4'b1100);
            w_valid = !narrow;
            n_valid = narrow;
            w_data = {8{32'hA5A5_0000 + 32'(cyc)}};
            n_data = 32'hC3C3_0000 + 32'(cyc);
        end
        w_valid = 1'b0;
        n_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // wide beats: one write per clock when unstalled
        run_load(1'b0, 256, 0, 1);
        run_load(1'b0, 2048, 0, 2);
        run_load(1'b0, 768, 1, 3);
        run_load(1'b0, 512, 2, 4);
        // narrow beats: packing across eight beats, full SRAM at 512 bytes
        run_load(1'b1, 256, 0, 5);
        run_load(1'b1, 512, 2, 6);
        run_load(1'b1, 256, 1, 7);
        // illegal sizes
        run_err(1'b0, 0);
        run_err(1'b0, 300);
        run_err(1'b0, 384);
        run_err(1'b1, 768);
        run_err(1'b1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule